// File: doc/BRIEF.md
# Block Erase Sequencer with Verify

This block wipes one block of a small on-chip storage array, using timing it generates itself. Software starts an erase in two command beats: an arming beat, then a go beat that carries the block number. The sequencer then runs three passes over the chosen block, one after another. The first pass clears every word to all-zeros. The second pass sets every word to all-ones. The third pass reads each word back and checks that it is all-ones.

A status byte shows whether the engine is ready, whether it is parked, and whether an erase error or a supply error is latched. A park request can pause the engine, but only between words. A resume request picks up at the word where it stopped.

Two inputs test the error paths:
- A supply-good input is sampled on the go beat. If it is low, the erase is refused before any pass starts.
- A fault-injection input forces the read-back pass to report a mismatch.

The array is a register file with a configurable number of blocks and words per block. Its reset contents are a computed seed pattern. Each word takes `WAIT_CYC + 1` clocks.

Top module: `erase_seq_top`

## Requirements
- R1: An erase starts only when an arm command (cmd_op 0) is followed directly by a go command (cmd_op 1). A go command with no arm before it does nothing. An arm command followed by any other command does nothing, and a later go command also does nothing.
- R2: The block number is taken from cmd_blk on the go beat. Only words of that block change during the erase.
- R3: A successful erase leaves every word of the block equal to all-ones. The status byte then reads 0x80 if no error was latched before.
- R4: Status bit 7 (ready) is 0 while the engine works. An erase with no park takes exactly 3·WPB·(WAIT_CYC+1) clocks of bit 7 low, which is 48 with the default parameters.
- R5: The passes run in a fixed order: clear to zero, then set to ones, then read-back. Each pass walks the words from index 0 upward.
- R6: If any word is not all-ones in the read-back pass, status bit 5 (erase error) is set when the erase ends. Fault injection held high also counts as a mismatch.
- R7: If supply_ok is low on the go beat, no pass runs and the array is not changed. Status bits 5 and 3 (supply error) are both set, and bit 7 stays 1.
- R8: A park command (cmd_op 2) during an erase takes effect at the next word boundary that comes after the command. While parked, status bits 7 and 6 read 1. A park command while idle is ignored.
- R9: A resume command (cmd_op 3) continues from the stored pass and word index. The erase ends with the same result, and the same total number of working clocks, as an erase with no park.
- R10: Bits 5 and 3 stay set through later operations until clr_status is high for a clock.
- R11: After reset the status byte is 0x80. Each word at array index a holds ((a·29) mod 2^DW) XOR the low DW bits of 0xA5A5A5A5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one clock per command |
| cmd_op | input | 2 | 0 arm, 1 go, 2 park, 3 resume |
| cmd_blk | input | BW | Block number, used on the go beat |
| supply_ok | input | 1 | Programming supply within range |
| fault_inject | input | 1 | Forces read-back mismatches |
| clr_status | input | 1 | Clears the error bits |
| rd_addr | input | AW | Array word address for the read port |
| rd_data | output | DW | Array word at rd_addr |
| status | output | 8 | Bit 7 ready, 6 parked, 5 erase error, 3 supply error |

## Verification
Every block is erased in turn, and the whole array is read back each time. This separates writes that land in the chosen block from writes that spill into other blocks.

A park command is then applied at every clock offset across the clear and set passes, and into the read-back pass. The contents seen while parked are compared with a prediction from the offset. This tells apart a park that is honoured at the correct word from one that is one word early or late, or in the wrong pass.

Further runs cover:
- a refused supply,
- fault injection,
- go commands in the wrong order,
- park and resume commands while idle.

These runs separate the two error bits, their stickiness, and the arming rule.

// File: rtl/erase_pkg.sv
package erase_pkg;

  typedef enum logic [1:0] {
    OP_ARM     = 2'd0,
    OP_GO      = 2'd1,
    OP_PARK    = 2'd2,
    OP_RESUME  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ZERO  = 2'd1,
    PH_ONES  = 2'd2,
    PH_CHECK = 2'd3
  } phase_e;

  // Reset contents of array word number addr (truncated by caller).
  function automatic logic [31:0] seed_word(input int unsigned addr);
    logic [31:0] prod;
    prod = 32'(addr * 29);
    return prod ^ 32'hA5A5A5A5;
  endfunction

  // Width of an index able to count to n-1, at least one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Next pass in the fixed erase order.
  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_ZERO:  return PH_ONES;
      PH_ONES:  return PH_CHECK;
      default:  return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/erase_array.sv
module erase_array
  import erase_pkg::*;
#(
  parameter int NBLK = 4,
  parameter int WPB  = 8,
  parameter int DW   = 8,
  localparam int NW  = NBLK * WPB,
  localparam int AW  = idx_width(NW)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_val,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] vf_addr,
  output logic [DW-1:0] vf_data
);

  logic [DW-1:0] mem [NW];

  generate
    for (genvar g = 0; g < NW; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[g] <= DW'(seed_word(g));
        else if (wr_en && wr_addr == AW'(g))
          mem[g] <= wr_val;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    vf_data = '0;
    if (int'(rd_addr) < NW) rd_data = mem[rd_addr];
    if (int'(vf_addr) < NW) vf_data = mem[vf_addr];
  end

endmodule

// File: rtl/erase_engine.sv
module erase_engine
  import erase_pkg::*;
#(
  parameter int NBLK     = 4,
  parameter int WPB      = 8,
  parameter int DW       = 8,
  parameter int WAIT_CYC = 1,
  localparam int NW      = NBLK * WPB,
  localparam int AW      = idx_width(NW),
  localparam int BW      = idx_width(NBLK),
  localparam int IW      = idx_width(WPB),
  localparam int CW      = idx_width(WAIT_CYC + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  op_e           cmd_op,
  input  logic [BW-1:0] cmd_blk,
  input  logic          supply_ok,
  input  logic          fault_inject,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_val,
  output logic [AW-1:0] vf_addr,
  input  logic [DW-1:0] vf_data,
  output logic          ev_abort,
  output logic          ev_fail,
  output logic          running,
  output logic          parked
);

  phase_e        phase_q;
  logic [BW-1:0] blk_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q, park_pend_q, park_q, vfail_q;

  // Named internal events
  logic active, step, last_word, go_ev, start_ev, word_bad, ev_done;

  function automatic logic [AW-1:0] word_addr(input logic [BW-1:0] b, input logic [IW-1:0] i);
    return AW'(int'(b) * WPB + int'(i));
  endfunction

  always_comb begin
    active    = (phase_q != PH_IDLE) && !park_q;
    step      = active && (cnt_q == CW'(WAIT_CYC));
    last_word = (idx_q == IW'(WPB - 1));
    go_ev     = cmd_valid && (cmd_op == OP_GO) && armed_q && (phase_q == PH_IDLE);
    start_ev  = go_ev && supply_ok;
    ev_abort  = go_ev && !supply_ok;
    wr_addr   = word_addr(blk_q, idx_q);
    vf_addr   = wr_addr;
    wr_en     = step && (phase_q == PH_ZERO || phase_q == PH_ONES);
    wr_val    = (phase_q == PH_ONES) ? '1 : '0;
    word_bad  = step && (phase_q == PH_CHECK) && ((vf_data != '1) || fault_inject);
    ev_done   = step && (phase_q == PH_CHECK) && last_word;
    ev_fail   = ev_done && (vfail_q || word_bad);
    running   = (phase_q != PH_IDLE);
    parked    = park_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      blk_q       <= '0;
      idx_q       <= '0;
      cnt_q       <= '0;
      armed_q     <= 1'b0;
      park_pend_q <= 1'b0;
      park_q      <= 1'b0;
      vfail_q     <= 1'b0;
    end else begin
      if (cmd_valid && phase_q == PH_IDLE)
        armed_q <= (cmd_op == OP_ARM);
      if (start_ev) begin
        phase_q     <= PH_ZERO;
        blk_q       <= cmd_blk;
        idx_q       <= '0;
        cnt_q       <= '0;
        vfail_q     <= 1'b0;
        park_pend_q <= 1'b0;
        park_q      <= 1'b0;
      end
      if (active) begin
        if (step) begin
          cnt_q   <= '0;
          vfail_q <= vfail_q | word_bad;
          if (last_word) begin
            idx_q   <= '0;
            phase_q <= next_phase(phase_q);
          end else begin
            idx_q <= idx_q + 1'b1;
          end
          if (park_pend_q && !ev_done) begin
            park_q      <= 1'b1;
            park_pend_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (cmd_valid && cmd_op == OP_PARK) park_pend_q <= 1'b1;
        if (ev_done) park_pend_q <= 1'b0;
      end
      if (park_q && cmd_valid && cmd_op == OP_RESUME)
        park_q <= 1'b0;
    end
  end

  // Block number is frozen for the whole erase
  assert_blk_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(blk_q));
  // Read-back pass is entered only from the set-to-ones pass
  assert_pass_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CHECK && $past(phase_q) != PH_CHECK) |-> $past(phase_q) == PH_ONES);
  // A refused go leaves the engine idle
  assert_abort_no_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (phase_q == PH_IDLE));
  // Parking happens only on a word boundary
  assert_park_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(park_q) |-> $past(step));
  // Resume keeps the stored position
  assert_resume_in_place_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(park_q) |-> ($stable(idx_q) && $stable(phase_q)));

endmodule

// File: rtl/erase_status.sv
module erase_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_abort,
  input  logic       ev_fail,
  input  logic       clr,
  input  logic       running,
  input  logic       parked,
  output logic [7:0] status
);

  logic err_erase_q, err_supply_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_erase_q  <= 1'b0;
      err_supply_q <= 1'b0;
    end else begin
      if (clr) begin
        err_erase_q  <= 1'b0;
        err_supply_q <= 1'b0;
      end
      if (ev_fail || ev_abort) err_erase_q  <= 1'b1;
      if (ev_abort)            err_supply_q <= 1'b1;
    end
  end

  always_comb begin
    status    = 8'h00;
    status[7] = !running || parked;
    status[6] = parked;
    status[5] = err_erase_q;
    status[3] = err_supply_q;
  end

  assert_fail_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> err_erase_q);
  assert_abort_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (err_erase_q && err_supply_q));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_erase_q && !clr) |=> err_erase_q);
  assert_supply_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_supply_q && !clr) |=> err_supply_q);

endmodule

// File: rtl/erase_seq_top.sv
module erase_seq_top
  import erase_pkg::*;
#(
  parameter int NBLK     = 4,
  parameter int WPB      = 8,
  parameter int DW       = 8,
  parameter int WAIT_CYC = 1,
  localparam int NW      = NBLK * WPB,
  localparam int AW      = idx_width(NW),
  localparam int BW      = idx_width(NBLK)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [BW-1:0] cmd_blk,
  input  logic          supply_ok,
  input  logic          fault_inject,
  input  logic          clr_status,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    status
);

  logic          wr_en, ev_abort, ev_fail, running, parked;
  logic [AW-1:0] wr_addr, vf_addr;
  logic [DW-1:0] wr_val, vf_data;

  erase_array #(.NBLK(NBLK), .WPB(WPB), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_val(wr_val),
    .rd_addr(rd_addr), .rd_data(rd_data), .vf_addr(vf_addr), .vf_data(vf_data)
  );

  erase_engine #(.NBLK(NBLK), .WPB(WPB), .DW(DW), .WAIT_CYC(WAIT_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op_e'(cmd_op)),
    .cmd_blk(cmd_blk), .supply_ok(supply_ok), .fault_inject(fault_inject),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_val(wr_val), .vf_addr(vf_addr),
    .vf_data(vf_data), .ev_abort(ev_abort), .ev_fail(ev_fail),
    .running(running), .parked(parked)
  );

  erase_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_abort(ev_abort), .ev_fail(ev_fail),
    .clr(clr_status), .running(running), .parked(parked), .status(status)
  );

endmodule

// File: tb/tb_erase_seq_top.sv
module tb_erase_seq_top;
  localparam int NBLK = 4, WPB = 8, DW = 8, WAIT_CYC = 1;
  localparam int P = WAIT_CYC + 1;
  localparam int RUN = 3 * WPB * P;

  logic clk = 0, rst_n = 0, cmd_valid = 0, supply_ok = 1, fault_inject = 0, clr_status = 0;
  logic [1:0] cmd_op = 0, cmd_blk = 0;
  logic [4:0] rd_addr = 0;
  logic [7:0] rd_data, status;
  logic [7:0] model [NBLK*WPB];
  int vectors = 0, miss = 0;

  erase_seq_top #(.NBLK(NBLK), .WPB(WPB), .DW(DW), .WAIT_CYC(WAIT_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .supply_ok(supply_ok), .fault_inject(fault_inject), .clr_status(clr_status),
    .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] seed(input int a);
    return 8'((a * 29) % 256) ^ 8'hA5;
  endfunction

  task automatic reseed();
    for (int a = 0; a < NBLK*WPB; a++) model[a] = seed(a);
  endtask

  task automatic check_block(input int b, input string req);
    for (int w = 0; w < WPB; w++) begin
      rd_addr = 5'(b*WPB + w); #1;
      chk(req, rd_data, model[b*WPB + w]);
    end
  endtask

  task automatic check_all(input string req);
    for (int b = 0; b < NBLK; b++) check_block(b, req);
  endtask

  task automatic send(input int op, input int b);
    cmd_valid = 1; cmd_op = 2'(op); cmd_blk = 2'(b);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    reseed();
  endtask

  // Run one erase; park_at = clock edge index at which the park command is sampled (0 = none)
  task automatic run_erase(input int b, input bit sup, input bit flt, input int park_at,
                           output int busy, output bit did_park);
    int t, n, p, e;
    logic [7:0] exp;
    bit done;
    busy = 0; did_park = 0; done = 0; t = 0;
    fault_inject = flt;
    supply_ok = sup;
    send(0, b);
    send(1, b);
    supply_ok = 1;
    while (!done && t < 4000) begin
      if (status[6]) begin
        did_park = 1;
        chk("R8", status, 8'hC0);
        n = park_at / P + 1;
        p = (n < WPB) ? n : WPB;
        e = (n > WPB) ? ((n - WPB < WPB) ? n - WPB : WPB) : 0;
        for (int w = 0; w < WPB; w++) begin
          if (n > WPB)       exp = (w < e) ? 8'hFF : 8'h00;
          else if (w < p)    exp = 8'h00;
          else               exp = model[b*WPB + w];
          rd_addr = 5'(b*WPB + w); #1;
          chk("R5", rd_data, exp);
        end
        send(3, b);
        t++;
      end else if (status[7]) begin
        done = 1;
      end else begin
        busy++;
        if (t == park_at - 1) begin
          cmd_valid = 1; cmd_op = 2'd2; cmd_blk = 2'(b);
        end
        @(negedge clk);
        cmd_valid = 0;
        t++;
      end
    end
    fault_inject = 0;
    if (sup) for (int w = 0; w < WPB; w++) model[b*WPB + w] = 8'hFF;
  endtask

  initial begin
    #(8 * 150000);
    miss++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    int busy;
    bit parked;
    reseed();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11", status, 8'h80);
    check_all("R11");

    // Every block erased in turn: R2, R3, R4
    for (int b = 0; b < NBLK; b++) begin
      run_erase(b, 1, 0, 0, busy, parked);
      chk("R4", busy, RUN);
      chk("R3", status, 8'h80);
      check_block(b, "R3");
      check_all("R2");
    end

    // Park sweep over every offset before the last word: R5, R8, R9
    do_reset();
    for (int s = 1; s < RUN - P; s++) begin
      run_erase(s % NBLK, 1, 0, s, busy, parked);
      chk("R8", parked, 1);
      chk("R9", busy, RUN);
      chk("R9", status, 8'h80);
      check_all("R9");
    end

    // Park and resume while idle are ignored: R8
    send(2, 0);
    chk("R8", status, 8'h80);
    send(3, 0);
    chk("R8", status, 8'h80);

    // Arming rule: R1
    do_reset();
    send(1, 1);
    @(negedge clk); @(negedge clk);
    chk("R1", status, 8'h80);
    send(0, 1); send(3, 1); send(1, 1);
    @(negedge clk); @(negedge clk);
    chk("R1", status, 8'h80);
    check_all("R1");

    // Refused supply: R7
    run_erase(2, 0, 0, 0, busy, parked);
    chk("R7", busy, 0);
    chk("R7", status, 8'hA8);
    check_all("R7");

    // Sticky errors across a good erase, then clear: R10
    run_erase(1, 1, 0, 0, busy, parked);
    chk("R10", status, 8'hA8);
    check_all("R10");
    clr_status = 1; @(negedge clk); clr_status = 0;
    chk("R10", status, 8'h80);

    // Read-back failure: R6
    run_erase(3, 1, 1, 0, busy, parked);
    chk("R6", busy, RUN);
    chk("R6", status, 8'hA0);
    check_block(3, "R6");
    clr_status = 1; @(negedge clk); clr_status = 0;
    chk("R10", status, 8'h80);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule